// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block brings up a contact smart card when the host asks for it. The host drives an active-low activation command and a reset line. The block divides its oscillator into a time unit T of `DIV` cycles and then works through a fixed order. It first turns on the card supply, then enables the I/O and auxiliary lines, then starts the card clock, and last hands the card reset line over to the host. Dropping the command at any point shuts everything down on the next oscillator edge.

Two ways of starting the clock are supported. If the host reset line is low when the command is asserted, the card clock starts on its own at a fixed offset. If the host reset line is high at that moment, the clock is held off until the host pulls the line low. This lets the host count an exact number of clock pulses before the reset edge. The host only has this control during a window. At the point where card reset is handed over, the clock is forced on, and from then on the host reset line only drives card reset. The card clock is half the oscillator rate and is gated so that every pulse is a full one.

Top module: `card_act_seq`

## Requirements
- R1: While rst_n is low, and after it is released with cmd_n high, vcc_en, io_en, card_clk, card_rst and active are all 0.
- R2: cmd_n is sampled low at an oscillator edge E0. vcc_en is 1 from E0 on. io_en becomes 1 exactly IO_UNITS*DIV edges after E0 and is 0 before that.
- R3: io_en is never 1 without vcc_en, and card_clk is never 1 without io_en.
- R4: If host_rst was 0 when the command was taken, the first card_clk pulse appears between 1 and 4 edges after edge E0+(IO_UNITS+CLK_UNITS)*DIV. There is no pulse before that.
- R5: If host_rst was 1 when the command was taken, card_clk stays 0 until host_rst is sampled 0 inside the clock window. The first pulse then follows within 1 to 4 edges.
- R6: If host_rst is still 1 at E0+(IO_UNITS+RST_UNITS)*DIV, the clock is forced on. The first pulse follows within 1 to 4 edges of that point.
- R7: card_rst and active are 0 before edge E0+(IO_UNITS+RST_UNITS)*DIV. From that edge on, active is 1 and card_rst equals host_rst.
- R8: Once active is 1, changing host_rst does not stop or delay card_clk.
- R9: When cmd_n is sampled 1, all outputs are 0 after the next edge.
- R10: Every card_clk pulse is high for exactly one oscillator cycle and is followed by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Activation command, active low |
| host_rst | input | 1 | Host reset request; delays the clock and drives card reset |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | I/O and auxiliary line enable |
| card_clk | output | 1 | Gated card clock at half the oscillator rate |
| card_rst | output | 1 | Card reset line |
| active | output | 1 | Activation complete |

## Verification
The bench builds the block with DIV=4 and keeps the default unit counts of 1, 4 and 7. This shortens a full activation to 32 oscillator cycles while keeping the ratio between the clock window and the reset point. With these values the bench can run every path many times. It covers the automatic clock start, the held clock released in mid-window, the clock forced on at the reset point, host reset toggling after activation, and release of the command part way through a sequence.

// File: rtl/card_act_seq.sv
module card_act_seq #(
  parameter int DIV       = 64,
  parameter int IO_UNITS  = 1,
  parameter int CLK_UNITS = 4,
  parameter int RST_UNITS = 7
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic host_rst,
  output logic vcc_en,
  output logic io_en,
  output logic card_clk,
  output logic card_rst,
  output logic active
);

  localparam int T3U = IO_UNITS + CLK_UNITS;
  localparam int T5U = IO_UNITS + RST_UNITS;
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int UW  = $clog2(T5U + 1);

  typedef enum logic [2:0] {S_IDLE, S_SUPPLY, S_IOEN, S_CLKWAIT, S_ACTIVE} st_t;

  st_t          st, st_nx;
  logic [PW-1:0] pre;
  logic [UW-1:0] units, units_nx;
  logic          tick, hold, clk_run, start;
  logic          ck_div, gate_q, card_clk_q;

  assign tick     = (pre == PW'(DIV - 1));
  assign units_nx = (tick && units != UW'(T5U)) ? units + 1'b1 : units;
  assign start    = (st == S_CLKWAIT && (!hold || !host_rst)) || st == S_ACTIVE;

  always_comb begin
    if (units_nx >= UW'(T5U))      st_nx = S_ACTIVE;
    else if (units_nx >= UW'(T3U)) st_nx = S_CLKWAIT;
    else if (units_nx >= UW'(IO_UNITS)) st_nx = S_IOEN;
    else                           st_nx = S_SUPPLY;
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pre     <= '0;
      units   <= '0;
      hold    <= 1'b0;
      clk_run <= 1'b0;
    end else if (cmd_n) begin
      st      <= S_IDLE;
      pre     <= '0;
      units   <= '0;
      hold    <= 1'b0;
      clk_run <= 1'b0;
    end else if (st == S_IDLE) begin
      st      <= (IO_UNITS == 0) ? S_IOEN : S_SUPPLY;
      pre     <= '0;
      units   <= '0;
      hold    <= host_rst;
    end else begin
      pre   <= tick ? '0 : pre + 1'b1;
      units <= units_nx;
      st    <= st_nx;
      if (start) clk_run <= 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_div     <= 1'b0;
      gate_q     <= 1'b0;
      card_clk_q <= 1'b0;
    end else begin
      ck_div <= ~ck_div;
      if (cmd_n) begin
        gate_q     <= 1'b0;
        card_clk_q <= 1'b0;
      end else begin
        if (ck_div) gate_q <= clk_run;
        card_clk_q <= !ck_div && gate_q;
      end
    end
  end

  assign vcc_en   = (st != S_IDLE);
  assign io_en    = (st == S_IOEN) || (st == S_CLKWAIT) || (st == S_ACTIVE);
  assign active   = (st == S_ACTIVE);
  assign card_rst = active && host_rst;
  assign card_clk = card_clk_q;

endmodule

module card_act_seq_chk (
  input logic osc_clk,
  input logic rst_n,
  input logic cmd_n,
  input logic vcc_en,
  input logic io_en,
  input logic card_clk,
  input logic card_rst,
  input logic active
);

  a_r3_io_needs_vcc: assert property (@(posedge osc_clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  a_r3_clk_needs_io: assert property (@(posedge osc_clk) disable iff (!rst_n)
    card_clk |-> io_en);

  a_r7_rst_only_active: assert property (@(posedge osc_clk) disable iff (!rst_n)
    card_rst |-> active);

  a_r9_release_clears: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cmd_n |=> (!vcc_en && !io_en && !card_clk && !active));

  a_r10_no_runt: assert property (@(posedge osc_clk) disable iff (!rst_n)
    card_clk |=> !card_clk);

endmodule

bind card_act_seq card_act_seq_chk u_chk (.*);

// File: tb/tb_card_act_seq.sv
`timescale 1ns/1ps
module tb_card_act_seq;
  localparam int DIV = 4;
  localparam int IOC = 1 * DIV;
  localparam int T3C = 5 * DIV;
  localparam int T5C = 8 * DIV;

  logic osc_clk = 1'b0, rst_n = 1'b0, cmd_n = 1'b1, host_rst = 1'b0;
  logic vcc_en, io_en, card_clk, card_rst, active;
  int checks = 0, failures = 0;

  always #2.5 osc_clk = ~osc_clk;

  card_act_seq #(.DIV(DIV)) dut (
    .osc_clk(osc_clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
    .vcc_en(vcc_en), .io_en(io_en), .card_clk(card_clk),
    .card_rst(card_rst), .active(active));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic outs_low(input string req);
    chk({vcc_en, io_en, card_clk, card_rst, active} == 5'b0, req,
        int'({vcc_en, io_en, card_clk, card_rst, active}), 0);
  endtask

  // Runs one activation. hold sets host_rst at command; drop_n drops it (-1 none).
  // toggle exercises host_rst after activation. Returns first clock pulse index.
  task automatic run(input bit hold, input int drop_n, input bit toggle,
                     input int n_end, output int first);
    bit prev_clk = 0;
    int rises_late = 0;
    first = -1;
    host_rst = hold;
    @(negedge osc_clk);
    cmd_n = 1'b0;
    for (int n = 0; n <= n_end; n++) begin
      @(negedge osc_clk);
      chk(vcc_en == 1'b1, "R2 vcc", vcc_en, 1);
      chk(io_en == (n >= IOC), "R2 io_en timing", io_en, int'(n >= IOC));
      chk(!(card_clk && !io_en), "R3 order", card_clk, io_en);
      chk(active == (n >= T5C), "R7 active timing", active, int'(n >= T5C));
      chk(card_rst == ((n >= T5C) && host_rst), "R7 card_rst", card_rst,
          int'((n >= T5C) && host_rst));
      chk(!(card_clk && prev_clk), "R10 pulse width", 2, 1);
      if (card_clk && !prev_clk) begin
        if (first < 0) first = n;
        if (n > T5C + 6) rises_late++;
      end
      prev_clk = card_clk;
      if (n == drop_n) host_rst = 1'b0;
      if (toggle && n == T5C + 6)  host_rst = 1'b1;
      if (toggle && n == T5C + 16) host_rst = 1'b0;
      if (toggle && n == T5C + 20) host_rst = 1'b1;
    end
    if (toggle)
      chk(rises_late >= (n_end - T5C - 6) / 2 - 1, "R8 clock unaffected",
          rises_late, (n_end - T5C - 6) / 2 - 1);
  endtask

  task automatic t_reset;
    @(negedge osc_clk);
    outs_low("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge osc_clk);
    outs_low("R1 after reset");
  endtask

  task automatic t_normal;
    int f;
    run(1'b0, -1, 1'b1, T5C + 30, f);
    chk(f >= T3C + 1 && f <= T3C + 4, "R4 clock start", f, T3C + 2);
    cmd_n = 1'b1;
    @(negedge osc_clk);
    outs_low("R9 release after active");
    host_rst = 1'b0;
    repeat (3) @(negedge osc_clk);
  endtask

  task automatic t_hold;
    int f, d;
    d = T3C + DIV;
    run(1'b1, d, 1'b0, T5C + 4, f);
    chk(f >= d + 1 && f <= d + 4, "R5 held clock start", f, d + 2);
    cmd_n = 1'b1;
    @(negedge osc_clk);
    outs_low("R9 release");
    repeat (3) @(negedge osc_clk);
  endtask

  task automatic t_forced;
    int f;
    run(1'b1, -1, 1'b0, T5C + 8, f);
    chk(f >= T5C + 1 && f <= T5C + 4, "R6 forced clock start", f, T5C + 2);
    chk(card_rst == 1'b1, "R7 card_rst follows high", card_rst, 1);
    cmd_n = 1'b1;
    host_rst = 1'b0;
    @(negedge osc_clk);
    outs_low("R9 release");
    repeat (3) @(negedge osc_clk);
  endtask

  task automatic t_abort;
    host_rst = 1'b0;
    @(negedge osc_clk);
    cmd_n = 1'b0;
    repeat (IOC + 3) @(negedge osc_clk);
    chk(io_en == 1'b1, "R2 io_en before abort", io_en, 1);
    cmd_n = 1'b1;
    @(negedge osc_clk);
    outs_low("R9 abort mid sequence");
    repeat (T5C) @(negedge osc_clk);
    outs_low("R9 stays idle");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_hold();
    t_forced();
    t_abort();
    t_normal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule